// File: doc/BRIEF.md
# Time-Multiplexed NOR2 Netlist Evaluator

This block computes an arbitrary acyclic circuit built only from two-input NOR gates. The circuit is not wired in; it lives in a small programmable table. Each gate number has one table entry, and that entry holds two source references. A source reference names either a primary input bit or the result of a gate with a lower number. A gate count register sets how many table entries take part. A set of output selectors chooses which value slots drive the result pins.

A start pulse captures an input vector. The engine then walks the gates in ascending number order and writes each result into a value register. In single-issue mode it handles one gate per cycle. In dual-issue mode it handles two gates per cycle, and a bypass preserves the same ordering when the second gate of a pair reads the first. After the last gate is written, the block raises `done` for one cycle. The selected result bits stay on `out_vec` until the next accepted start.

Completion is signalled rather than fixed, so the caller does not need to know the gate count or the mode. The data path has no back-pressure:
- A start is accepted only while `busy` is low.
- The result is held, not handed off, so no ready signal is needed.

Top module: `nor2_netlist_eval`

## Requirements
- R1: After reset, `busy` and `done` are low, the gate count is 0, every output selector is 0 and the value register is cleared, so `out_vec` reads 0.
- R2: Value slot k (0 ≤ k < N_IN) holds primary input bit k captured at start. Slot N_IN+g holds the NOR of the two slots referenced by table entry g.
- R3: In single-issue mode (`dual_mode`=0 at start) with gate count G>0, `busy` is high for G cycles after the accepting clock edge. `done` is high in the G-th cycle after that edge.
- R4: In dual-issue mode (`dual_mode`=1 at start) with gate count G>0, the evaluation takes ceil(G/2) cycles. Gates are paired (0,1), (2,3), and so on; an odd last gate issues alone.
- R5: Dual-issue results equal single-issue results. This includes a second gate of a pair that references the first gate of the same pair.
- R6: `done` lasts exactly one cycle and coincides with `busy` low. `out_vec` stays unchanged while idle, unless an output selector is written or a start is accepted.
- R7: A start pulse while `busy` is high is ignored. The captured inputs, mode, latency and results of the running evaluation are unchanged.
- R8: With gate count 0, an accepted start raises `done` in the next cycle without raising `busy`, and it captures the inputs.
- R9: `out_vec[j]` equals the value slot named by output selector j. A selector write takes effect from the next cycle.
- R10: An accepted start clears every gate slot, so a gate slot at or beyond the gate count reads 0 after the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one gate table entry |
| tbl_gate | input | GW | Gate number written |
| tbl_ref_a | input | RW | First source reference of that gate |
| tbl_ref_b | input | RW | Second source reference of that gate |
| cnt_we | input | 1 | Write the gate count |
| cnt_val | input | CW | Gate count G (0..MAX_G) |
| osel_we | input | 1 | Write one output selector |
| osel_slot | input | OSW | Output bit index being set |
| osel_ref | input | RW | Value slot routed to that output bit |
| dual_mode | input | 1 | Issue mode captured at start: 0 means one gate per cycle, 1 means two |
| start | input | 1 | Start pulse, accepted only while idle |
| in_vec | input | N_IN | Primary input vector captured at start |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| out_vec | output | N_OUT | Selected value slots |

## Verification
Two pairs of events can land in the same cycle, and each is provoked on purpose.

The first pair is the two gates of one dual-issue step where the second gate reads the first. The bench builds a chain netlist in which every odd gate consumes its even neighbour. It runs that netlist in both modes with the same vectors and compares the results bit for bit against a behavioural evaluation.

The second pair is a fresh start arriving while an evaluation is still running. The bench pulses start mid-run with a different vector and the opposite mode. It then checks that `busy`, `done` and `out_vec` follow the first request cycle for cycle.

// File: rtl/nor2_eval_pkg.sv
package nor2_eval_pkg;

  typedef enum logic {
    ISSUE_ONE = 1'b0,
    ISSUE_TWO = 1'b1
  } issue_e;

  function automatic logic nor2(input logic a, input logic b);
    return ~(a | b);
  endfunction

endpackage

// File: rtl/nor2_gate_table.sv
module nor2_gate_table #(
  parameter int DEPTH = 32,
  parameter int GW    = 5,
  parameter int RW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [GW-1:0] waddr,
  input  logic [RW-1:0] wref_a,
  input  logic [RW-1:0] wref_b,
  input  logic [GW-1:0] raddr0,
  input  logic [GW-1:0] raddr1,
  output logic [RW-1:0] rd0_a,
  output logic [RW-1:0] rd0_b,
  output logic [RW-1:0] rd1_a,
  output logic [RW-1:0] rd1_b
);

  logic [RW-1:0] ref_a_mem [DEPTH];
  logic [RW-1:0] ref_b_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      ref_a_mem[waddr] <= wref_a;
      ref_b_mem[waddr] <= wref_b;
    end
  end

  // Two combinational read ports serve the two issue lanes.
  assign rd0_a = ref_a_mem[raddr0];
  assign rd0_b = ref_b_mem[raddr0];
  assign rd1_a = ref_a_mem[raddr1];
  assign rd1_b = ref_b_mem[raddr1];

endmodule

// File: rtl/nor2_slot_pick.sv
module nor2_slot_pick #(
  parameter int SLOTS = 40,
  parameter int RW    = 6
) (
  input  logic [SLOTS-1:0] vals,
  input  logic [RW-1:0]    sel,
  output logic             bit_o
);

  always_comb begin
    bit_o = 1'b0;
    if (int'(sel) < SLOTS) bit_o = vals[sel];
  end

endmodule

// File: rtl/nor2_issue_pair.sv
module nor2_issue_pair
  import nor2_eval_pkg::*;
#(
  parameter int SLOTS = 40,
  parameter int RW    = 6
) (
  input  logic [SLOTS-1:0] vals,
  input  logic [RW-1:0]    a0,
  input  logic [RW-1:0]    b0,
  input  logic [RW-1:0]    a1,
  input  logic [RW-1:0]    b1,
  input  logic [RW-1:0]    slot0,
  output logic             r0,
  output logic             r1
);

  logic va0, vb0, va1, vb1;
  logic in1a, in1b;

  nor2_slot_pick #(.SLOTS(SLOTS), .RW(RW)) u_pa0 (.vals(vals), .sel(a0), .bit_o(va0));
  nor2_slot_pick #(.SLOTS(SLOTS), .RW(RW)) u_pb0 (.vals(vals), .sel(b0), .bit_o(vb0));
  nor2_slot_pick #(.SLOTS(SLOTS), .RW(RW)) u_pa1 (.vals(vals), .sel(a1), .bit_o(va1));
  nor2_slot_pick #(.SLOTS(SLOTS), .RW(RW)) u_pb1 (.vals(vals), .sel(b1), .bit_o(vb1));

  assign r0 = nor2(va0, vb0);

  // Lane 1 reads lane 0's fresh result when it names lane 0's slot.
  assign in1a = (a1 == slot0) ? r0 : va1;
  assign in1b = (b1 == slot0) ? r0 : vb1;
  assign r1   = nor2(in1a, in1b);

endmodule

// File: rtl/nor2_netlist_eval.sv
module nor2_netlist_eval
  import nor2_eval_pkg::*;
#(
  parameter  int N_IN  = 8,
  parameter  int MAX_G = 32,
  parameter  int N_OUT = 4,
  localparam int SLOTS = N_IN + MAX_G,
  localparam int RW    = $clog2(SLOTS),
  localparam int GW    = (MAX_G > 1) ? $clog2(MAX_G) : 1,
  localparam int CW    = $clog2(MAX_G + 1),
  localparam int OSW   = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [GW-1:0]    tbl_gate,
  input  logic [RW-1:0]    tbl_ref_a,
  input  logic [RW-1:0]    tbl_ref_b,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_val,
  input  logic             osel_we,
  input  logic [OSW-1:0]   osel_slot,
  input  logic [RW-1:0]    osel_ref,
  input  logic             dual_mode,
  input  logic             start,
  input  logic [N_IN-1:0]  in_vec,
  output logic             busy,
  output logic             done,
  output logic [N_OUT-1:0] out_vec
);

  logic [SLOTS-1:0] val_q, val_d;
  logic [CW-1:0]    pc_q, cnt_q;
  issue_e           mode_q;
  logic             busy_q, done_q;
  logic [RW-1:0]    osel_q [N_OUT];

  logic [GW-1:0]    ra0, ra1;
  logic [RW-1:0]    ta0, tb0, ta1, tb1;
  logic [RW-1:0]    slot0, slot1;
  logic             r0, r1;
  logic [CW:0]      pc_plus1, pc_next;
  logic             pair_ok, last_step;

  assign ra0   = pc_q[GW-1:0];
  assign ra1   = GW'(ra0 + 1'b1);
  assign slot0 = RW'(N_IN) + RW'(pc_q);
  assign slot1 = RW'(slot0 + 1'b1);

  nor2_gate_table #(.DEPTH(MAX_G), .GW(GW), .RW(RW)) u_table (
    .clk    (clk),
    .we     (tbl_we),
    .waddr  (tbl_gate),
    .wref_a (tbl_ref_a),
    .wref_b (tbl_ref_b),
    .raddr0 (ra0),
    .raddr1 (ra1),
    .rd0_a  (ta0),
    .rd0_b  (tb0),
    .rd1_a  (ta1),
    .rd1_b  (tb1)
  );

  nor2_issue_pair #(.SLOTS(SLOTS), .RW(RW)) u_pair (
    .vals  (val_q),
    .a0    (ta0),
    .b0    (tb0),
    .a1    (ta1),
    .b1    (tb1),
    .slot0 (slot0),
    .r0    (r0),
    .r1    (r1)
  );

  // Issue width for this step and the completion test.
  always_comb begin
    pc_plus1  = {1'b0, pc_q} + (CW+1)'(1);
    pair_ok   = (mode_q == ISSUE_TWO) && (pc_plus1 < {1'b0, cnt_q});
    pc_next   = pair_ok ? {1'b0, pc_q} + (CW+1)'(2) : pc_plus1;
    last_step = (pc_next >= {1'b0, cnt_q});
  end

  always_comb begin
    val_d        = val_q;
    val_d[slot0] = r0;
    if (pair_ok) val_d[slot1] = r1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      pc_q   <= '0;
      cnt_q  <= '0;
      mode_q <= ISSUE_ONE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      for (int j = 0; j < N_OUT; j++) osel_q[j] <= '0;
    end else begin
      done_q <= 1'b0;
      if (cnt_we)  cnt_q <= cnt_val;
      if (osel_we) osel_q[osel_slot] <= osel_ref;
      if (busy_q) begin
        val_q <= val_d;
        pc_q  <= CW'(pc_next);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start) begin
        val_q  <= {{MAX_G{1'b0}}, in_vec};
        pc_q   <= '0;
        mode_q <= dual_mode ? ISSUE_TWO : ISSUE_ONE;
        if (cnt_q == '0) done_q <= 1'b1;
        else             busy_q <= 1'b1;
      end
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    nor2_slot_pick #(.SLOTS(SLOTS), .RW(RW)) u_out (
      .vals  (val_q),
      .sel   (osel_q[j]),
      .bit_o (out_vec[j])
    );
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/nor2_eval_checker.sv
module nor2_eval_checker #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             osel_we,
  input logic             busy,
  input logic             done,
  input logic [N_OUT-1:0] out_vec,
  input logic [N_IN-1:0]  prim
);

  // R6: completion only while idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6: one-cycle pulse unless a new zero-length run starts
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R6: outputs held while idle and untouched
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && !osel_we |=> $stable(out_vec));

  // R7: a start during a run does not recapture inputs
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(prim));

  // R3: the end of a run is always announced
  p_fell_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3: done has a cause in the prior cycle
  p_done_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) || $past(start));

endmodule

bind nor2_netlist_eval nor2_eval_checker #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .osel_we (osel_we),
  .busy    (busy),
  .done    (done),
  .out_vec (out_vec),
  .prim    (val_q[N_IN-1:0])
);

// File: tb/tb_nor2_netlist_eval.sv
module tb_nor2_netlist_eval;

  localparam int N_IN  = 8;
  localparam int MAX_G = 32;
  localparam int N_OUT = 4;
  localparam int SLOTS = N_IN + MAX_G;
  localparam int RW    = 6;
  localparam int GW    = 5;
  localparam int CW    = 6;
  localparam int OSW   = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             tbl_we = 1'b0;
  logic [GW-1:0]    tbl_gate = '0;
  logic [RW-1:0]    tbl_ref_a = '0, tbl_ref_b = '0;
  logic             cnt_we = 1'b0;
  logic [CW-1:0]    cnt_val = '0;
  logic             osel_we = 1'b0;
  logic [OSW-1:0]   osel_slot = '0;
  logic [RW-1:0]    osel_ref = '0;
  logic             dual_mode = 1'b0;
  logic             start = 1'b0;
  logic [N_IN-1:0]  in_vec = '0;
  logic             busy, done;
  logic [N_OUT-1:0] out_vec;

  nor2_netlist_eval #(.N_IN(N_IN), .MAX_G(MAX_G), .N_OUT(N_OUT)) dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_gate(tbl_gate),
    .tbl_ref_a(tbl_ref_a), .tbl_ref_b(tbl_ref_b), .cnt_we(cnt_we),
    .cnt_val(cnt_val), .osel_we(osel_we), .osel_slot(osel_slot),
    .osel_ref(osel_ref), .dual_mode(dual_mode), .start(start),
    .in_vec(in_vec), .busy(busy), .done(done), .out_vec(out_vec)
  );

  // Behavioural reference state
  int    m_ta [MAX_G];
  int    m_tb [MAX_G];
  int    m_sel [N_OUT];
  int    m_cnt = 0;
  bit    m_vals [SLOTS];
  bit    m_busy = 0, m_done = 0, m_nd = 0;
  int    m_rem = 0;
  string ctl_tag = "R1", out_tag = "R1";
  int    n_cmp = 0, n_bad = 0, cyc = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_eval();
    for (int i = 0; i < SLOTS; i++) m_vals[i] = 1'b0;
    for (int i = 0; i < N_IN; i++)  m_vals[i] = in_vec[i];
    for (int g = 0; g < m_cnt; g++)
      m_vals[N_IN+g] = !(m_vals[m_ta[g]] | m_vals[m_tb[g]]);
  endtask

  function automatic logic [N_OUT-1:0] exp_out();
    logic [N_OUT-1:0] e;
    for (int j = 0; j < N_OUT; j++) e[j] = m_vals[m_sel[j]];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rem = 0; m_cnt = 0;
      for (int i = 0; i < SLOTS; i++) m_vals[i] = 1'b0;
      for (int j = 0; j < N_OUT; j++) m_sel[j] = 0;
    end else begin
      m_nd = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin m_busy = 0; m_nd = 1; end
      end else if (start) begin
        model_eval();
        m_rem = dual_mode ? (m_cnt + 1) / 2 : m_cnt;
        if (m_rem == 0) m_nd = 1; else m_busy = 1;
      end
      m_done = m_nd;
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    check(busy === m_busy, ctl_tag, "busy", int'(busy), int'(m_busy));
    check(done === m_done, ctl_tag, "done", int'(done), int'(m_done));
    if (!m_busy) check(out_vec === exp_out(), out_tag, "out_vec", int'(out_vec), int'(exp_out()));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL %s watchdog actual=%0d expected=<150000", ctl_tag, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic set_gate(int g, int a, int b);
    tbl_we = 1; tbl_gate = GW'(g); tbl_ref_a = RW'(a); tbl_ref_b = RW'(b);
    @(posedge clk); #1; m_ta[g] = a; m_tb[g] = b;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic set_cnt(int n);
    cnt_we = 1; cnt_val = CW'(n);
    @(posedge clk); #1; m_cnt = n;
    @(negedge clk); cnt_we = 0;
  endtask

  task automatic set_sel(int j, int r);
    osel_we = 1; osel_slot = OSW'(j); osel_ref = RW'(r);
    @(posedge clk); #1; m_sel[j] = r;
    @(negedge clk); osel_we = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && !m_done; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(logic [N_IN-1:0] vec, bit dual);
    in_vec = vec; dual_mode = dual; start = 1;
    @(negedge clk); start = 0;
    wait_done();
  endtask

  task automatic run_interrupted(logic [N_IN-1:0] v1, logic [N_IN-1:0] v2, bit dual);
    in_vec = v1; dual_mode = dual; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    in_vec = v2; dual_mode = !dual; start = 1;
    @(negedge clk); start = 0;
    wait_done();
  endtask

  task automatic rand_net(int n);
    for (int g = 0; g < n; g++)
      set_gate(g, $urandom_range(N_IN + g - 1, 0), $urandom_range(N_IN + g - 1, 0));
    set_cnt(n);
  endtask

  task automatic sel_last(int n);
    for (int j = 0; j < N_OUT; j++) set_sel(j, N_IN + n - N_OUT + j);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 / R3: random netlists, single issue
    ctl_tag = "R3"; out_tag = "R2";
    rand_net(20); sel_last(20);
    run(8'hA5, 0); run(8'h00, 0); run(8'hFF, 0); run(8'h3C, 0);

    // R4 / R5: same netlist, dual issue, and an odd gate count
    ctl_tag = "R4"; out_tag = "R5";
    run(8'hA5, 1); run(8'h00, 1); run(8'hFF, 1); run(8'h3C, 1);
    rand_net(13); sel_last(13);
    run(8'h5A, 1); run(8'h81, 1);
    ctl_tag = "R3"; out_tag = "R2";
    run(8'h5A, 0);

    // R5: chain where every pair's second gate reads its first (bypass)
    set_gate(0, 0, 1);
    for (int g = 1; g < MAX_G; g++)
      set_gate(g, N_IN + g - 1, (g % 3 == 0) ? N_IN + g - 1 : g % N_IN);
    set_cnt(MAX_G); sel_last(MAX_G);
    ctl_tag = "R4"; out_tag = "R5";
    run(8'h01, 1); run(8'hC3, 1); run(8'h7E, 1);
    ctl_tag = "R3"; out_tag = "R2";
    run(8'h01, 0); run(8'hC3, 0);

    // R7: start pulses during a run are ignored
    ctl_tag = "R7"; out_tag = "R7";
    run_interrupted(8'h96, 8'h69, 0);
    run_interrupted(8'h0F, 8'hF0, 1);

    // R6: outputs hold while idle
    ctl_tag = "R6"; out_tag = "R6";
    repeat (6) @(negedge clk);

    // R9: selector rewrites while idle
    ctl_tag = "R9"; out_tag = "R9";
    set_sel(0, 0); set_sel(1, N_IN + 5); set_sel(2, 7); set_sel(3, N_IN + MAX_G - 1);
    repeat (2) @(negedge clk);

    // R10: shorter run leaves higher gate slots cleared
    ctl_tag = "R10"; out_tag = "R10";
    set_cnt(4);
    for (int j = 0; j < N_OUT; j++) set_sel(j, N_IN + 10 + j);
    run(8'hFF, 0);
    set_sel(0, N_IN + 3);
    repeat (2) @(negedge clk);

    // R8: zero gate count
    ctl_tag = "R8"; out_tag = "R8";
    set_cnt(0);
    for (int j = 0; j < N_OUT; j++) set_sel(j, j * 2);
    run(8'h55, 0); run(8'hAA, 1);
    for (int j = 0; j < N_OUT; j++) set_sel(j, N_IN + j);
    run(8'hFF, 0);

    // R1: reset mid-life returns the reset state
    ctl_tag = "R1"; out_tag = "R1";
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule